// File: doc/BRIEF.md
# USB Control-Read Endpoint Sequencer

This block runs the device side of the control endpoint while the host performs a control read. Decoded token pulses arrive from the packet layer: SETUP, IN, OUT, and a zero-length qualifier that comes with OUT. The block follows the transfer through the setup, data and status stages. It answers every token with an ACK or NAK decision one cycle later. It also keeps a byte count for the endpoint bank, which both the CPU writes and the host status bytes update.

The CPU sees three flags: setup-received, out-received and tx-ready. To clear a flag, the CPU writes 0 to its bit. To hand a filled IN bank to the host, the CPU clears tx-ready. A SETUP overrides everything else. Once the status stage begins, the block drops any IN data the CPU has not yet sent, and the CPU can no longer change tx-ready.

Top module: `usb_ctrl_rd_ep`

## Requirements
- R1: After reset all three flags are 0, the stage is idle (stage=0), the byte count is 0 and hs_valid is 0.
- R2: A SETUP token is ACKed in every stage and wins over an IN or OUT in the same cycle. On the next cycle setup-received is 1, out-received is 0, tx-ready is 1 (bank empty), the byte count is 0 and the stage is data (stage=1).
- R3: Every token is answered exactly one cycle later by hs_valid=1, with hs_ack=1 for ACK and 0 for NAK. No token means hs_valid=0.
- R4: In the data stage, an IN is NAKed while setup-received is set or while the bank has not been marked filled. Otherwise it is ACKed, and the bank then becomes empty: tx-ready=1 and count 0. An IN in the status stage is NAKed.
- R5: A flag write clears each flag whose bit in flag_wdata is 0 (bit 0 setup-received, bit 1 out-received, bit 2 tx-ready) and leaves it alone where the bit is 1. A hardware set in the same cycle as a clear wins.
- R6: Clearing tx-ready while it is 1 in the data stage marks the IN bank as filled.
- R7: The first OUT in the data stage is NAKed and moves the stage to status (stage=2). It discards the IN bank: count 0, filled mark dropped. During the status stage a CPU clear of tx-ready has no effect.
- R8: An OUT in the status stage is ACKed. It sets out-received and tx-ready and returns the stage to idle, where the block waits for SETUP.
- R9: An ACKed status OUT with tok_zlp=1 resets the byte count to 0. With tok_zlp=0 the count is kept.
- R10: In the idle stage, IN and OUT tokens are NAKed and change no flag.
- R11: cpu_push adds one to the count only in the data stage, while the bank is not marked filled and the count is below DEPTH. A token that empties the bank in the same cycle takes priority over the push.
- R12: host_byte adds one to the count only in the status stage, saturating at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_setup | input | 1 | Decoded SETUP token pulse |
| tok_in | input | 1 | Decoded IN token pulse |
| tok_out | input | 1 | Decoded OUT token pulse |
| tok_zlp | input | 1 | Qualifies tok_out as a zero-length packet |
| cpu_push | input | 1 | CPU writes one IN byte into the bank |
| host_byte | input | 1 | One OUT data byte received from the host |
| flag_wr | input | 1 | CPU flag register write strobe |
| flag_wdata | input | 3 | Write data; a 0 bit clears the matching flag |
| flag_setup | output | 1 | Setup-received flag |
| flag_out | output | 1 | Out-received flag |
| flag_txrdy | output | 1 | Tx-ready flag (bank free for CPU) |
| hs_valid | output | 1 | Handshake decision valid |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| stage | output | 2 | 0 idle, 1 data, 2 status |
| byte_cnt | output | $clog2(DEPTH+1) | Endpoint byte count |

## Verification
The assertions assume that tok_in and tok_out never pulse in the same cycle. The packet layer delivers one token at a time, and only SETUP is allowed to coincide with another token. The random stimulus chooses at most one of IN and OUT per cycle. It still lets SETUP, CPU pushes, host bytes and flag writes land together with those tokens, so the priority rules are exercised. Directed runs walk a complete control read, fill the bank to saturation, and clear a flag in the same cycle as its hardware set.

// File: rtl/usb_ctrl_rd_ep.sv
module usb_ctrl_rd_ep #(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tok_setup,
  input  logic                         tok_in,
  input  logic                         tok_out,
  input  logic                         tok_zlp,
  input  logic                         cpu_push,
  input  logic                         host_byte,
  input  logic                         flag_wr,
  input  logic [2:0]                   flag_wdata,
  output logic                         flag_setup,
  output logic                         flag_out,
  output logic                         flag_txrdy,
  output logic                         hs_valid,
  output logic                         hs_ack,
  output logic [1:0]                   stage,
  output logic [$clog2(DEPTH+1)-1:0]   byte_cnt
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_DATA = 2'd1, ST_STAT = 2'd2;

  logic          full, full_n;
  logic          s_n, o_n, t_n, hv_n, ha_n;
  logic [1:0]    st_n;
  logic [CW-1:0] cnt_n;

  wire clr_s   = flag_wr & ~flag_wdata[0];
  wire clr_o   = flag_wr & ~flag_wdata[1];
  wire clr_t   = flag_wr & ~flag_wdata[2];
  wire in_data = stage == ST_DATA;
  wire in_stat = stage == ST_STAT;
  wire room    = byte_cnt < CMAX;

  always_comb begin
    s_n   = flag_setup & ~clr_s;
    o_n   = flag_out & ~clr_o;
    t_n   = flag_txrdy;
    full_n = full;
    st_n  = stage;
    cnt_n = byte_cnt;
    hv_n  = 1'b0;
    ha_n  = 1'b0;

    if (clr_t && in_data && flag_txrdy) begin
      t_n    = 1'b0;
      full_n = 1'b1;
    end
    if (cpu_push && in_data && !full && room)
      cnt_n = byte_cnt + CW'(1);
    if (host_byte && in_stat && room)
      cnt_n = byte_cnt + CW'(1);

    if (tok_setup) begin
      hv_n   = 1'b1;
      ha_n   = 1'b1;
      s_n    = 1'b1;
      o_n    = 1'b0;
      t_n    = 1'b1;
      full_n = 1'b0;
      cnt_n  = '0;
      st_n   = ST_DATA;
    end else if (tok_in) begin
      hv_n = 1'b1;
      if (in_data && !flag_setup && full) begin
        ha_n   = 1'b1;
        full_n = 1'b0;
        cnt_n  = '0;
        t_n    = 1'b1;
      end
    end else if (tok_out) begin
      hv_n = 1'b1;
      if (in_data) begin
        st_n   = ST_STAT;
        cnt_n  = '0;
        full_n = 1'b0;
        t_n    = flag_txrdy;
      end else if (in_stat) begin
        ha_n = 1'b1;
        o_n  = 1'b1;
        t_n  = 1'b1;
        st_n = ST_IDLE;
        if (tok_zlp) cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_setup <= 1'b0;
      flag_out   <= 1'b0;
      flag_txrdy <= 1'b0;
      full       <= 1'b0;
      stage      <= ST_IDLE;
      byte_cnt   <= '0;
      hs_valid   <= 1'b0;
      hs_ack     <= 1'b0;
    end else begin
      flag_setup <= s_n;
      flag_out   <= o_n;
      flag_txrdy <= t_n;
      full       <= full_n;
      stage      <= st_n;
      byte_cnt   <= cnt_n;
      hs_valid   <= hv_n;
      hs_ack     <= ha_n;
    end
  end
endmodule

// File: rtl/usb_ctrl_rd_ep_chk.sv
module usb_ctrl_rd_ep_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tok_setup,
  input logic                       tok_in,
  input logic                       tok_out,
  input logic                       tok_zlp,
  input logic                       cpu_push,
  input logic                       host_byte,
  input logic                       flag_wr,
  input logic [2:0]                 flag_wdata,
  input logic                       flag_setup,
  input logic                       flag_out,
  input logic                       flag_txrdy,
  input logic                       hs_valid,
  input logic                       hs_ack,
  input logic [1:0]                 stage,
  input logic [$clog2(DEPTH+1)-1:0] byte_cnt
);
  wire any_tok = tok_setup | tok_in | tok_out;

  a_r3_tokens_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tok_in && tok_out));
  a_r3_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
    any_tok |=> hs_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !any_tok |=> !hs_valid);
  a_r3_ack_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> hs_valid);
  a_r2_setup_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> hs_ack && flag_setup && !flag_out && flag_txrdy && byte_cnt == '0 && stage == 2'd1);
  a_r4_nak_while_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && !tok_setup && flag_setup) |=> !hs_ack);
  a_r7_first_status_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_out && !tok_setup && stage == 2'd1) |=> !hs_ack && stage == 2'd2 && byte_cnt == '0);
  a_r7_txrdy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd2 && !tok_setup && !tok_out) |=> $stable(flag_txrdy));
  a_r8_status_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_out && !tok_setup && stage == 2'd2) |=> hs_ack && flag_out && flag_txrdy && stage == 2'd0);
  a_r9_zlp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_out && tok_zlp && !tok_setup && stage == 2'd2) |=> byte_cnt == '0);
  a_r10_idle_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd0 && !tok_setup && (tok_in || tok_out)) |=> !hs_ack);
  a_r11_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind usb_ctrl_rd_ep usb_ctrl_rd_ep_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/usb_ctrl_rd_ep_tb.sv
module usb_ctrl_rd_ep_tb;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_setup = 0, tok_in = 0, tok_out = 0, tok_zlp = 0;
  logic cpu_push = 0, host_byte = 0, flag_wr = 0;
  logic [2:0] flag_wdata = 3'b111;
  logic flag_setup, flag_out, flag_txrdy, hs_valid, hs_ack;
  logic [1:0] stage;
  logic [CW-1:0] byte_cnt;

  int checks = 0, errors = 0;

  logic m_s = 0, m_o = 0, m_t = 0, m_full = 0, m_hv = 0, m_ha = 0;
  logic [1:0] m_st = 0;
  int m_cnt = 0;
  string tag;

  always #5 clk = ~clk;

  usb_ctrl_rd_ep #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string pick_tag(logic s, logic i, logic o, logic z, logic p,
                                     logic hb, logic fw, logic [2:0] fd);
    if (s) return "R2";
    if (i) return (m_st == 0) ? "R10" : "R4";
    if (o) begin
      if (m_st == 0) return "R10";
      if (m_st == 1) return "R7";
      return z ? "R9" : "R8";
    end
    if (fw && !fd[2]) return (m_st == 2) ? "R7" : "R6";
    if (fw) return "R5";
    if (hb) return "R12";
    if (p) return "R11";
    return "R5";
  endfunction

  task automatic model(logic s, logic i, logic o, logic z, logic p,
                       logic hb, logic fw, logic [2:0] fd);
    logic ns, no, nt, nf, hv, ha;
    logic [1:0] nst;
    int nc;
    ns = m_s & ~(fw & ~fd[0]);
    no = m_o & ~(fw & ~fd[1]);
    nt = m_t; nf = m_full; nst = m_st; nc = m_cnt; hv = 0; ha = 0;
    if (fw && !fd[2] && m_st == 1 && m_t) begin nt = 0; nf = 1; end
    if (p && m_st == 1 && !m_full && m_cnt < DEPTH) nc = m_cnt + 1;
    if (hb && m_st == 2 && m_cnt < DEPTH) nc = m_cnt + 1;
    if (s) begin
      hv = 1; ha = 1; ns = 1; no = 0; nt = 1; nf = 0; nc = 0; nst = 1;
    end else if (i) begin
      hv = 1;
      if (m_st == 1 && !m_s && m_full) begin ha = 1; nf = 0; nc = 0; nt = 1; end
    end else if (o) begin
      hv = 1;
      if (m_st == 1) begin nst = 2; nc = 0; nf = 0; nt = m_t; end
      else if (m_st == 2) begin
        ha = 1; no = 1; nt = 1; nst = 0;
        if (z) nc = 0;
      end
    end
    m_s = ns; m_o = no; m_t = nt; m_full = nf; m_st = nst; m_cnt = nc; m_hv = hv; m_ha = ha;
  endtask

  task automatic step(logic s, logic i, logic o, logic z, logic p,
                      logic hb, logic fw, logic [2:0] fd);
    @(negedge clk);
    tok_setup = s; tok_in = i; tok_out = o; tok_zlp = z;
    cpu_push = p; host_byte = hb; flag_wr = fw; flag_wdata = fd;
    tag = pick_tag(s, i, o, z, p, hb, fw, fd);
    model(s, i, o, z, p, hb, fw, fd);
    @(posedge clk);
    #1;
    tok_setup = 0; tok_in = 0; tok_out = 0; tok_zlp = 0;
    cpu_push = 0; host_byte = 0; flag_wr = 0; flag_wdata = 3'b111;
    chk("R3 hs_valid", int'(hs_valid), int'(m_hv));
    chk({tag, " hs_ack"}, int'(hs_ack), int'(m_ha));
    chk({tag, " flag_setup"}, int'(flag_setup), int'(m_s));
    chk({tag, " flag_out"}, int'(flag_out), int'(m_o));
    chk({tag, " flag_txrdy"}, int'(flag_txrdy), int'(m_t));
    chk({tag, " stage"}, int'(stage), int'(m_st));
    chk({tag, " byte_cnt"}, int'(byte_cnt), m_cnt);
  endtask

  task automatic idle_step(); step(0,0,0,0,0,0,0,3'b111); endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flag_setup", int'(flag_setup), 0);
    chk("R1 flag_out", int'(flag_out), 0);
    chk("R1 flag_txrdy", int'(flag_txrdy), 0);
    chk("R1 stage", int'(stage), 0);
    chk("R1 byte_cnt", int'(byte_cnt), 0);
    chk("R1 hs_valid", int'(hs_valid), 0);
    @(negedge clk) rst_n = 1'b1;

    // R10 tokens before any SETUP
    step(0,1,0,0,0,0,0,3'b111);
    step(0,0,1,0,0,0,0,3'b111);
    // R2 SETUP, then IN NAKed while setup flag set (R4)
    step(1,0,0,0,1,0,0,3'b111);
    step(0,1,0,0,0,0,0,3'b111);
    chk("R4 nak with setup flag", int'(hs_ack), 0);
    // R5 writing ones changes nothing, then clear setup flag
    step(0,0,0,0,0,0,1,3'b111);
    step(0,0,0,0,0,0,1,3'b110);
    // R11 push bytes, R4 IN NAK on unfilled bank
    for (int k = 0; k < 3; k++) step(0,0,0,0,1,0,0,3'b111);
    step(0,1,0,0,0,0,0,3'b111);
    chk("R4 nak unfilled", int'(hs_ack), 0);
    // R6 mark filled, push ignored after, IN ACK with concurrent push (R11)
    step(0,0,0,0,0,0,1,3'b011);
    step(0,0,0,0,1,0,0,3'b111);
    chk("R11 push ignored when filled", int'(byte_cnt), 3);
    step(0,1,0,0,1,0,0,3'b111);
    chk("R4 in ack empties bank", int'(byte_cnt), 0);
    // R7 fill again, first status OUT discards
    step(0,0,0,0,1,0,0,3'b111);
    step(0,0,0,0,0,0,1,3'b011);
    step(0,0,1,0,0,0,1,3'b011);
    chk("R7 first status nak", int'(hs_ack), 0);
    step(0,0,0,0,0,0,1,3'b011);
    step(0,1,0,0,0,0,0,3'b111);
    // R12 host bytes, R8/R9 ack without zlp keeps count
    step(0,0,0,0,0,1,0,3'b111);
    step(0,0,0,0,1,1,0,3'b111);
    step(0,0,1,0,0,0,0,3'b111);
    chk("R9 count kept", int'(byte_cnt), 2);
    step(0,0,0,0,0,1,0,3'b111);
    chk("R12 host byte ignored idle", int'(byte_cnt), 2);
    // R5 clear out flag together with SETUP: setup set wins, out cleared
    step(1,0,0,0,0,0,1,3'b000);
    chk("R5 set wins over clear", int'(flag_setup), 1);
    step(0,0,1,0,0,0,0,3'b111);
    step(0,0,0,0,0,1,0,3'b111);
    step(0,0,1,1,0,1,0,3'b111);
    chk("R9 zlp clears", int'(byte_cnt), 0);
    // R2 SETUP with IN together, R11 saturation
    step(1,1,0,0,0,0,0,3'b111);
    for (int k = 0; k < DEPTH + 5; k++) step(0,0,0,0,1,0,0,3'b111);
    chk("R11 saturate", int'(byte_cnt), DEPTH);
    step(1,0,1,0,0,0,0,3'b111);

    for (int n = 0; n < 4000; n++) begin
      int r;
      logic s, i, o;
      r = int'($urandom_range(99));
      s = (r < 3);
      i = (r >= 3 && r < 15);
      o = (r >= 15 && r < 22);
      step(s, i, o, 1'($urandom_range(1)),
           ($urandom_range(99) < 30), ($urandom_range(99) < 20),
           ($urandom_range(99) < 15), 3'($urandom_range(7)));
    end
    repeat (2) idle_step();
    finish_run();
  end
endmodule